// File: doc/BRIEF.md
# Batch and Rank Packet Scheduler

This block is the output-port arbiter of an on-chip router. Each cycle it looks at up to `N_REQ` waiting packets and picks at most one. Each packet carries three tags: a batch number set when it was injected, an application identifier and an injection timestamp. The sources form the batches and work out the application ranks. The scheduler itself only compares these tags.

In the default policy, packets from an older batch always go before packets from a newer one. Within one batch, the application with the better rank goes first. A small writable table turns each application identifier into a rank. Every router holds the same table contents, so each router orders the same packets the same way. A policy input can switch the port to plain round-robin or to oldest-timestamp-first, so the scheduling policies can be compared. The grant is registered. It appears one clock after the requests are sampled, as a valid flag, a one-hot vector and a binary index.

Top module: `pkt_sched_arb`

## Requirements
- R1: When no `req_valid` bit is set at a clock edge, the following cycle shows `gnt_valid` = 0 and `gnt_onehot` = 0.
- R2: A grant issued at an edge reflects the requests sampled at that edge. `gnt_onehot` has exactly one bit set, at position `gnt_idx`, and that requester was valid.
- R3: With `policy` = 2'b00, a request from an older batch wins over any request from a newer batch, whatever the ranks.
- R4: Batch age is compared modulo 2^`BATCH_W`. Batch x is older than batch y when (x − y) mod 2^`BATCH_W` has its top bit set, so batch 7 is older than batch 0 for a 3-bit batch.
- R5: With `policy` = 2'b00 and equal batches, the request whose application maps to the numerically smaller rank wins. Rank 0 is the best rank.
- R6: With `policy` = 2'b00, equal batch and equal rank, the older timestamp wins. Timestamps are compared modulo 2^`TS_W` in the same way as batches. If the timestamps are also equal, the lowest input index wins.
- R7: After reset, the rank of application a is a mod 2^`RANK_W`. A table write presented at an edge is not yet seen by the arbitration at that same edge. It is used from the next edge on.
- R8: With `policy` = 2'b01, the search starts at a pointer and goes upward with wrap-around. The first valid requester wins. After every grant, in any policy, the pointer moves to one past the granted index. Reset sets the pointer to 0.
- R9: With `policy` = 2'b10, only timestamps matter: the oldest timestamp wins, and the lowest index wins a tie. Batch and rank are ignored.
- R10: `policy` = 2'b11 behaves exactly as 2'b00.
- R11: While `rst` is high at an edge, the following cycle shows no grant, and all state returns to its reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | 00 batch-rank, 01 round-robin, 10 oldest-first, 11 batch-rank |
| req_valid | input | N_REQ | One bit per waiting packet |
| req_batch | input | N_REQ*BATCH_W | Batch number per requester, requester i at bits i*BATCH_W |
| req_app | input | N_REQ*APP_W | Application identifier per requester |
| req_ts | input | N_REQ*TS_W | Injection timestamp per requester |
| rank_we | input | 1 | Rank table write enable |
| rank_waddr | input | APP_W | Application whose rank is written |
| rank_wdata | input | RANK_W | New rank value |
| gnt_valid | output | 1 | A grant is held this cycle |
| gnt_onehot | output | N_REQ | One-hot grant |
| gnt_idx | output | IDX_W | Index of the granted requester |

## Verification
Two cases are hard to reach from the ports. In the first, the batch counter has wrapped, so the older batch carries the numerically larger number. In the second, a rank write lands in the same cycle as a contest that depends on the rank being changed. Directed steps place batches 7 and 0 side by side. They also write new ranks for two competing applications while both are requesting, so the old order must hold for one grant and flip on the next. A long random phase then mixes policies, table writes and batch windows near the wrap point. Every cycle is compared against a behavioural model that tracks its own rank table and rotation pointer.

// File: rtl/pkt_sched_pkg.sv
package pkt_sched_pkg;
  typedef enum logic [1:0] {
    POL_BATCH_RANK  = 2'b00,
    POL_ROUND_ROBIN = 2'b01,
    POL_OLDEST      = 2'b10,
    POL_SPARE       = 2'b11
  } policy_e;
endpackage

// File: rtl/psa_rank_table.sv
module psa_rank_table #(
  parameter int N_REQ  = 4,
  parameter int APP_W  = 3,
  parameter int RANK_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [APP_W-1:0]          waddr,
  input  logic [RANK_W-1:0]         wdata,
  input  logic [N_REQ*APP_W-1:0]    raddr,
  output logic [N_REQ*RANK_W-1:0]   rdata
);
  localparam int NUM_APPS = 1 << APP_W;

  logic [RANK_W-1:0] rank_q [NUM_APPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < NUM_APPS; a++) rank_q[a] <= RANK_W'(a);
    end else if (we) begin
      rank_q[waddr] <= wdata;
    end
  end

  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_rd
    assign rdata[gi*RANK_W +: RANK_W] = rank_q[raddr[gi*APP_W +: APP_W]];
  end

  AST_RANK_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |=> rank_q[$past(waddr)] == $past(wdata)); // R7
endmodule

// File: rtl/psa_key_select.sv
module psa_key_select #(
  parameter int N_REQ   = 4,
  parameter int BATCH_W = 3,
  parameter int RANK_W  = 3,
  parameter int TS_W    = 8,
  localparam int IDX_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0]         valid,
  input  logic [N_REQ*BATCH_W-1:0] batch,
  input  logic [N_REQ*RANK_W-1:0]  rank,
  input  logic [N_REQ*TS_W-1:0]    ts,
  input  logic                     age_only,
  output logic                     found,
  output logic [IDX_W-1:0]         idx
);
  logic [BATCH_W-1:0] batch_a [N_REQ];
  logic [RANK_W-1:0]  rank_a  [N_REQ];
  logic [TS_W-1:0]    ts_a    [N_REQ];

  always_comb begin
    for (int i = 0; i < N_REQ; i++) begin
      batch_a[i] = batch[i*BATCH_W +: BATCH_W];
      rank_a[i]  = rank[i*RANK_W +: RANK_W];
      ts_a[i]    = ts[i*TS_W +: TS_W];
    end
  end

  function automatic logic batch_older(input logic [BATCH_W-1:0] x, input logic [BATCH_W-1:0] y);
    logic [BATCH_W-1:0] d;
    d = x - y;
    return d[BATCH_W-1];
  endfunction

  function automatic logic ts_older(input logic [TS_W-1:0] x, input logic [TS_W-1:0] y);
    logic [TS_W-1:0] d;
    d = x - y;
    return d[TS_W-1];
  endfunction

  // challenger (c) strictly beats incumbent (h); ties keep the lower index
  function automatic logic beats(
    input logic [BATCH_W-1:0] bc, input logic [RANK_W-1:0] rc, input logic [TS_W-1:0] tc,
    input logic [BATCH_W-1:0] bh, input logic [RANK_W-1:0] rh, input logic [TS_W-1:0] th,
    input logic ignore_prio);
    if (!ignore_prio && bc != bh) return batch_older(bc, bh);
    if (!ignore_prio && rc != rh) return rc < rh;
    if (tc != th) return ts_older(tc, th);
    return 1'b0;
  endfunction

  logic [IDX_W-1:0] best [N_REQ+1];
  logic             have [N_REQ+1];

  assign best[0] = '0;
  assign have[0] = 1'b0;

  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_chain
    logic take;
    assign take = valid[gi] && (!have[gi] ||
                  beats(batch_a[gi], rank_a[gi], ts_a[gi],
                        batch_a[best[gi]], rank_a[best[gi]], ts_a[best[gi]], age_only));
    assign have[gi+1] = have[gi] | valid[gi];
    assign best[gi+1] = take ? IDX_W'(gi) : best[gi];
  end

  assign found = have[N_REQ];
  assign idx   = best[N_REQ];
endmodule

// File: rtl/psa_rr_pick.sv
module psa_rr_pick #(
  parameter int N_REQ  = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] valid,
  input  logic             upd,
  input  logic [IDX_W-1:0] upd_idx,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W:0]   cand;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    cand  = '0;
    for (int k = 0; k < N_REQ; k++) begin
      cand = {1'b0, ptr_q} + (IDX_W+1)'(k);
      if (cand >= (IDX_W+1)'(N_REQ)) cand = cand - (IDX_W+1)'(N_REQ);
      if (!found && valid[cand[IDX_W-1:0]]) begin
        found = 1'b1;
        idx   = cand[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      ptr_q <= '0;
    else if (upd) ptr_q <= (upd_idx == IDX_W'(N_REQ-1)) ? '0 : upd_idx + 1'b1;
  end

  AST_RR_FROM_VALID: assert property (@(posedge clk) disable iff (rst)
    found |-> valid[idx]); // R8
  AST_RR_PTR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (found && idx != ptr_q) |-> !valid[ptr_q]); // R8
endmodule

// File: rtl/pkt_sched_arb.sv
module pkt_sched_arb
  import pkt_sched_pkg::*;
#(
  parameter int N_REQ   = 4,
  parameter int BATCH_W = 3,
  parameter int APP_W   = 3,
  parameter int RANK_W  = 3,
  parameter int TS_W    = 8,
  localparam int IDX_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               policy,
  input  logic [N_REQ-1:0]         req_valid,
  input  logic [N_REQ*BATCH_W-1:0] req_batch,
  input  logic [N_REQ*APP_W-1:0]   req_app,
  input  logic [N_REQ*TS_W-1:0]    req_ts,
  input  logic                     rank_we,
  input  logic [APP_W-1:0]         rank_waddr,
  input  logic [RANK_W-1:0]        rank_wdata,
  output logic                     gnt_valid,
  output logic [N_REQ-1:0]         gnt_onehot,
  output logic [IDX_W-1:0]         gnt_idx
);
  policy_e pol;
  assign pol = policy_e'(policy);

  logic [N_REQ*RANK_W-1:0] req_rank;
  logic                    key_found, rr_found, sel_found;
  logic [IDX_W-1:0]        key_idx, rr_idx, sel_idx;
  logic                    age_only;

  assign age_only = (pol == POL_OLDEST);

  psa_rank_table #(.N_REQ(N_REQ), .APP_W(APP_W), .RANK_W(RANK_W)) u_rank (
    .clk(clk), .rst(rst), .we(rank_we), .waddr(rank_waddr), .wdata(rank_wdata),
    .raddr(req_app), .rdata(req_rank));

  psa_key_select #(.N_REQ(N_REQ), .BATCH_W(BATCH_W), .RANK_W(RANK_W), .TS_W(TS_W)) u_key (
    .valid(req_valid), .batch(req_batch), .rank(req_rank), .ts(req_ts),
    .age_only(age_only), .found(key_found), .idx(key_idx));

  psa_rr_pick #(.N_REQ(N_REQ)) u_rr (
    .clk(clk), .rst(rst), .valid(req_valid), .upd(sel_found), .upd_idx(sel_idx),
    .found(rr_found), .idx(rr_idx));

  always_comb begin
    if (pol == POL_ROUND_ROBIN) begin
      sel_found = rr_found;
      sel_idx   = rr_idx;
    end else begin
      sel_found = key_found;
      sel_idx   = key_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid  <= 1'b0;
      gnt_onehot <= '0;
      gnt_idx    <= '0;
    end else begin
      gnt_valid  <= sel_found;
      gnt_idx    <= sel_idx;
      gnt_onehot <= sel_found ? (N_REQ'(1) << sel_idx) : '0;
    end
  end

  AST_ONEHOT_GNT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_onehot)); // R2
  AST_GNT_WAS_REQ: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> (($past(req_valid) & gnt_onehot) != '0)); // R2
  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> gnt_onehot[gnt_idx]); // R2
  AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (rst)
    (req_valid == '0) |=> !gnt_valid); // R1
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!gnt_valid && gnt_onehot == '0)); // R11
endmodule

// File: tb/sim_pkt_sched_arb.sv
`timescale 1ns/1ps
module sim_pkt_sched_arb;
  localparam int N = 4, BW = 3, AW = 3, RW = 3, TW = 8, IW = 2;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] policy;
  logic [N-1:0] req_valid;
  logic [N*BW-1:0] req_batch;
  logic [N*AW-1:0] req_app;
  logic [N*TW-1:0] req_ts;
  logic rank_we;
  logic [AW-1:0] rank_waddr;
  logic [RW-1:0] rank_wdata;
  logic gnt_valid;
  logic [N-1:0] gnt_onehot;
  logic [IW-1:0] gnt_idx;

  always #4 clk = ~clk;

  pkt_sched_arb u0 (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string tag = "R11";

  // stimulus and reference state
  bit v[N];
  int bt[N], ap[N], ts[N];
  int pol;
  bit we; int wa, wd;
  int rk[8];
  int ptr;

  function automatic bit mod_older(int x, int y, int w);
    int d;
    d = (x - y) & ((1 << w) - 1);
    return d >= (1 << (w - 1));
  endfunction

  function automatic bit better(int c, int h, bit age);
    if (!age && bt[c] != bt[h]) return mod_older(bt[c], bt[h], BW);
    if (!age && rk[ap[c]] != rk[ap[h]]) return rk[ap[c]] < rk[ap[h]];
    if (ts[c] != ts[h]) return mod_older(ts[c], ts[h], TW);
    return 0;
  endfunction

  task automatic step();
    bit ev; int ei;
    for (int i = 0; i < N; i++) begin
      req_valid[i] = v[i];
      req_batch[i*BW +: BW] = BW'(bt[i]);
      req_app[i*AW +: AW] = AW'(ap[i]);
      req_ts[i*TW +: TW] = TW'(ts[i]);
    end
    policy = 2'(pol);
    rank_we = we; rank_waddr = AW'(wa); rank_wdata = RW'(wd);
    ev = 0; ei = 0;
    if (pol == 1) begin
      for (int k = 0; k < N; k++) begin
        int c = (ptr + k) % N;
        if (!ev && v[c]) begin ev = 1; ei = c; end
      end
    end else begin
      for (int i = 0; i < N; i++)
        if (v[i] && (!ev || better(i, ei, pol == 2))) begin ev = 1; ei = i; end
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (gnt_valid !== ev || gnt_onehot !== (ev ? N'(1) << ei : N'(0)) ||
        (ev && gnt_idx !== IW'(ei))) begin
      miscompares++;
      $display("FAIL %s: got valid=%0b onehot=%b idx=%0d, expected valid=%0b idx=%0d",
               tag, gnt_valid, gnt_onehot, gnt_idx, ev, ei);
    end
    if (we) rk[wa] = wd;
    if (ev) ptr = (ei + 1) % N;
    we = 0;
  endtask

  task automatic set_req(int i, bit vv, int b, int a, int t);
    v[i] = vv; bt[i] = b; ap[i] = a; ts[i] = t;
  endtask

  task automatic clear_reqs();
    for (int i = 0; i < N; i++) set_req(i, 0, 0, 0, 0);
  endtask

  initial begin
    rst = 1; policy = 0; req_valid = '0; req_batch = '0; req_app = '0; req_ts = '0;
    rank_we = 0; rank_waddr = '0; rank_wdata = '0;
    we = 0; wa = 0; wd = 0; pol = 0; ptr = 0;
    for (int a = 0; a < 8; a++) rk[a] = a;
    clear_reqs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;   // R11: reset state
    if (gnt_valid !== 1'b0 || gnt_onehot !== '0) begin
      miscompares++;
      $display("FAIL R11: got valid=%0b onehot=%b, expected 0 0", gnt_valid, gnt_onehot);
    end
    rst = 0;

    tag = "R1"; clear_reqs(); step(); step();

    tag = "R3"; clear_reqs();
    set_req(0, 1, 3, 0, 10); set_req(1, 1, 2, 7, 50); step();

    tag = "R4"; clear_reqs();
    set_req(1, 1, 0, 0, 10); set_req(2, 1, 7, 6, 90); step();

    tag = "R5"; clear_reqs();
    set_req(0, 1, 4, 5, 1); set_req(3, 1, 4, 2, 200); step();

    tag = "R6"; clear_reqs();
    set_req(0, 1, 1, 3, 40); set_req(2, 1, 1, 3, 30); set_req(3, 1, 1, 3, 250); step();
    set_req(0, 1, 1, 3, 30); set_req(2, 1, 1, 3, 30); set_req(3, 1, 1, 3, 30); step();

    tag = "R7"; clear_reqs();
    set_req(1, 1, 5, 5, 0); set_req(2, 1, 5, 2, 0);
    we = 1; wa = 5; wd = 0; step();   // old table: app 2 wins
    we = 1; wa = 2; wd = 7; step();   // app 5 now rank 0
    step();

    tag = "R8"; pol = 1; clear_reqs();
    for (int i = 0; i < N; i++) set_req(i, 1, 0, 0, 0);
    repeat (6) step();
    v[0] = 0; v[2] = 0; repeat (3) step();

    tag = "R9"; pol = 2; clear_reqs();
    set_req(0, 1, 0, 0, 100); set_req(1, 1, 6, 7, 20); set_req(3, 1, 6, 7, 20); step();
    set_req(2, 1, 0, 0, 250); step();

    tag = "R10"; pol = 3; clear_reqs();
    set_req(0, 1, 2, 1, 9); set_req(1, 1, 1, 6, 99); step();

    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      int base = $urandom_range(0, 7);
      int tb = $urandom_range(0, 255);
      pol = $urandom_range(0, 3);
      for (int i = 0; i < N; i++)
        set_req(i, $urandom_range(0, 3) != 0, (base + $urandom_range(0, 3)) % 8,
                $urandom_range(0, 7), (tb + $urandom_range(0, 100)) % 256);
      if ($urandom_range(0, 7) == 0) begin
        we = 1; wa = $urandom_range(0, 7); wd = $urandom_range(0, 7);
      end
      step();
    end

    tag = "R11"; rst = 1; clear_reqs(); v[0] = 1;
    req_valid = 4'b0001;
    @(posedge clk); @(negedge clk);
    vectors++;
    if (gnt_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R11: got valid=%0b during reset, expected 0", gnt_valid);
    end
    rst = 0; ptr = 0;
    for (int a = 0; a < 8; a++) rk[a] = a;
    pol = 1; for (int i = 0; i < N; i++) set_req(i, 1, 0, 0, 0); step();
    pol = 0; clear_reqs(); set_req(0, 1, 0, 7, 0); set_req(1, 1, 0, 6, 0); step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule